// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block sequences a processor core into and out of a low-power stop-grant state. A stop-clock request comes in active low and with no timing relation to the block clock. The block passes it through a flop synchronizer. It then raises a request for the bus interface to send a stop-grant acknowledge, and waits for the bus side to accept that request through a valid/ready handshake. Only after that handshake does it pull the clock enables of the core units low. The enables for the bus interface and the interrupt controller are never touched. While the core is stopped, a status output tells the bus and interrupt logic that snooping and interrupt service must continue.

When the request is released, every core clock enable comes back in the same cycle. A resume indication is then held for a fixed number of cycles so that downstream clocks can settle, and after that the block returns to normal running. The request can also be withdrawn while the acknowledge is still waiting for the bus. In that case the acknowledge still completes, and the core is never stopped. The block drives only enable levels and status flags. Clock gating cells, the bus transaction encoding and the snoop and interrupt logic sit outside it.

Top module: `stopclk_ctrl`

## Requirements
- R1: `stop_req_n` passes through `SYNC_STAGES` flops. When it falls, `ack_valid` goes high at the (`SYNC_STAGES`+1)-th rising clock edge after the fall.
- R2: Once `ack_valid` is high, it stays high until a cycle in which `ack_ready` is also high. While it waits, all core clock enables stay high.
- R3: On the edge after a handshake in which the synchronized request is still active, every bit of `core_clk_en` goes low and `snoop_irq_en` goes high. The core enables go low only right after such a handshake.
- R4: `bus_clk_en` and `intc_clk_en` are high in every state, including during and after reset.
- R5: While stopped, a release of `stop_req_n` puts the block into resume at the (`SYNC_STAGES`+1)-th edge after the release. In that cycle every `core_clk_en` bit is high, `resume_ind` is high and `snoop_irq_en` is low.
- R6: `resume_ind` stays high for exactly `RESUME_CYCLES` cycles, after which the block is in RUN.
- R7: If the synchronized request is inactive when the acknowledge handshake completes, the block goes directly to resume, and `core_clk_en` never drops.
- R8: After reset the block is in RUN: all enables are high, and `ack_valid`, `snoop_irq_en` and `resume_ind` are low.
- R9: A request that becomes active during resume does not shorten or extend the resume. It is acted on from RUN one cycle after resume ends.
- R10: `state_o` reports the state as follows: RUN=0, acknowledge pending=1, stop-grant=2, resume=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| ack_ready | input | 1 | Bus interface accepts the stop-grant acknowledge |
| ack_valid | output | 1 | Request to send the stop-grant acknowledge |
| core_clk_en | output | CORE_UNITS | Clock enables of the core units |
| bus_clk_en | output | 1 | Bus interface clock enable, always high |
| intc_clk_en | output | 1 | Interrupt controller clock enable, always high |
| snoop_irq_en | output | 1 | Snooping and interrupt service must continue (stopped state) |
| resume_ind | output | 1 | Execution-resume indication |
| state_o | output | 2 | Current state code |

## Verification
The bench builds the block with `SYNC_STAGES`=3, `CORE_UNITS`=3 and `RESUME_CYCLES`=5. None of these are the defaults, so an off-by-one in the synchronizer depth or the resume count shows up as a shifted edge. The resume window is longer than the synchronizer delay. This means a request raised right at the start of resume is synchronized while resume is still running, which is the case R9 needs. With three core units, a mistake in the per-unit enable generation is visible in more than one bit.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ACKP   = 2'd1,
    ST_HALT   = 2'd2,
    ST_RESUME = 2'd3
  } pstate_t;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic pstate_t next_state(pstate_t cur, logic req, logic hs, logic done);
    case (cur)
      ST_RUN:  return req ? ST_ACKP : ST_RUN;
      ST_ACKP: begin
        if (hs) return req ? ST_HALT : ST_RESUME;
        return ST_ACKP;
      end
      ST_HALT: return req ? ST_HALT : ST_RESUME;
      default: return done ? ST_RUN : ST_RESUME;
    endcase
  endfunction

  function automatic logic core_gated(pstate_t s);
    return s == ST_HALT;
  endfunction

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  initial begin
    depth_chk: assert (STAGES >= 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
  import stopclk_pkg::*;
#(
  parameter int RESUME_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_act,
  input  logic    ack_ready,
  output pstate_t state,
  output logic    ack_valid,
  output logic    hs_evt,
  output logic    resume_done
);
  localparam int CW = cnt_width(RESUME_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(RESUME_CYCLES - 1);

  pstate_t       nxt;
  logic [CW-1:0] cnt;

  assign ack_valid   = (state == ST_ACKP);
  assign hs_evt      = ack_valid && ack_ready;
  assign resume_done = (state == ST_RESUME) && (cnt == '0);
  assign nxt         = next_state(state, req_act, hs_evt, resume_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state != ST_RESUME && nxt == ST_RESUME) cnt <= LOAD;
      else if (state == ST_RESUME && cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_ready |=> ack_valid);
  // R1
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) && !req_act |=> (state == ST_RUN));
  // R6
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |=> (state == ST_RUN));
  // R7
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt && !req_act |=> (state == ST_RESUME));
  // R9
  resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESUME) && !resume_done |=> (state == ST_RESUME));
endmodule

// File: rtl/stopclk_en_drv.sv
module stopclk_en_drv
  import stopclk_pkg::*;
#(
  parameter int CORE_UNITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pstate_t               state,
  input  logic                  hs_evt,
  output logic [CORE_UNITS-1:0] core_clk_en,
  output logic                  bus_clk_en,
  output logic                  intc_clk_en,
  output logic                  snoop_irq_en,
  output logic                  resume_ind
);
  for (genvar u = 0; u < CORE_UNITS; u++) begin : g_unit
    assign core_clk_en[u] = !core_gated(state);
  end

  assign bus_clk_en   = 1'b1;
  assign intc_clk_en  = 1'b1;
  assign snoop_irq_en = (state == ST_HALT);
  assign resume_ind   = (state == ST_RESUME);

  // R3
  gate_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en[0]) |-> $past(hs_evt));
  // R3
  snoop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_irq_en |-> (core_clk_en == '0));
  // R5
  resume_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_ind) |-> (&core_clk_en) && !snoop_irq_en);
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CORE_UNITS    = 4,
  parameter int RESUME_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_req_n,
  input  logic                  ack_ready,
  output logic                  ack_valid,
  output logic [CORE_UNITS-1:0] core_clk_en,
  output logic                  bus_clk_en,
  output logic                  intc_clk_en,
  output logic                  snoop_irq_en,
  output logic                  resume_ind,
  output logic [1:0]            state_o
);
  logic    req_n_sync;
  logic    req_act;
  pstate_t state;
  logic    hs_evt;
  logic    resume_done;

  stopclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(stop_req_n), .sync_out(req_n_sync));

  assign req_act = !req_n_sync;

  stopclk_fsm #(.RESUME_CYCLES(RESUME_CYCLES)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_act(req_act), .ack_ready(ack_ready),
    .state(state), .ack_valid(ack_valid), .hs_evt(hs_evt),
    .resume_done(resume_done));

  stopclk_en_drv #(.CORE_UNITS(CORE_UNITS)) en_i (
    .clk(clk), .rst_n(rst_n), .state(state), .hs_evt(hs_evt),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .intc_clk_en(intc_clk_en), .snoop_irq_en(snoop_irq_en),
    .resume_ind(resume_ind));

  assign state_o = state;

  // R8
  reset_run_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (state_o == 2'd0) && !ack_valid);
  // R4
  side_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_irq_en |-> bus_clk_en && intc_clk_en);
endmodule

// File: tb/stopclk_ctrl_tb_top.sv
module stopclk_ctrl_tb_top;
  localparam int S  = 3;
  localparam int CU = 3;
  localparam int RC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic ack_ready = 1'b0;
  logic ack_valid, bus_clk_en, intc_clk_en, snoop_irq_en, resume_ind;
  logic [CU-1:0] core_clk_en;
  logic [1:0] state_o;

  int errors = 0;
  int checks = 0;
  bit saw_gate = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stopclk_ctrl #(.SYNC_STAGES(S), .CORE_UNITS(CU), .RESUME_CYCLES(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .ack_ready(ack_ready),
    .ack_valid(ack_valid), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .intc_clk_en(intc_clk_en), .snoop_irq_en(snoop_irq_en),
    .resume_ind(resume_ind), .state_o(state_o));

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // behavioural reference, stepped on every rising edge
  int m_state = 0;
  int m_cnt = 0;
  bit q[$];
  initial for (int i = 0; i < S; i++) q.push_back(1'b1);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; q.delete();
      for (int i = 0; i < S; i++) q.push_back(1'b1);
    end else begin
      bit ra;
      bit hs;
      ra = !q[0];
      hs = (m_state == 1) && ack_ready;
      case (m_state)
        0: if (ra) m_state = 1;
        1: if (hs) begin
             if (ra) m_state = 2; else begin m_state = 3; m_cnt = RC; end
           end
        2: if (!ra) begin m_state = 3; m_cnt = RC; end
        default: begin m_cnt--; if (m_cnt == 0) m_state = 0; end
      endcase
      q.push_back(stop_req_n);
      void'(q.pop_front());
    end
    #5;
    chk(state_o == m_state, "R10 state", state_o, m_state);
    chk(ack_valid == (m_state == 1), "R2 ack_valid", ack_valid, m_state == 1);
    chk(core_clk_en == ((m_state == 2) ? '0 : {CU{1'b1}}), "R3 core_clk_en",
        core_clk_en, (m_state == 2) ? 0 : (1 << CU) - 1);
    chk(snoop_irq_en == (m_state == 2), "R3 snoop_irq_en", snoop_irq_en, m_state == 2);
    chk(resume_ind == (m_state == 3), "R5 resume_ind", resume_ind, m_state == 3);
    chk(bus_clk_en && intc_clk_en, "R4 side enables", {bus_clk_en, intc_clk_en}, 3);
    if (core_clk_en != {CU{1'b1}}) saw_gate = 1;
  end

  task automatic wait_for_ack(output int n);
    n = 0;
    do begin @(posedge clk); #5; n++; end while (!ack_valid && n < 50);
  endtask

  task automatic wait_for_resume(output int n);
    n = 0;
    do begin @(posedge clk); #5; n++; end while (!resume_ind && n < 50);
  endtask

  task automatic count_resume(output int len);
    len = 1;
    do begin @(posedge clk); #5; if (resume_ind) len++; end while (resume_ind && len < 50);
  endtask

  initial begin
    int n;
    int len;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(state_o == 0 && !ack_valid && core_clk_en == {CU{1'b1}} && !snoop_irq_en
        && !resume_ind && bus_clk_en && intc_clk_en, "R8 reset", state_o, 0);
    rst_n = 1'b1;
    ack_ready = 1'b1;  // ready in RUN has no effect
    repeat (4) @(negedge clk);
    chk(state_o == 0, "R8 idle run", state_o, 0);
    ack_ready = 1'b0;

    // Scenario A: full stop and resume
    stop_req_n = 1'b0;
    wait_for_ack(n);
    chk(n == S + 1, "R1 ack latency", n, S + 1);
    repeat (3) begin
      @(posedge clk); #5;
      chk(ack_valid && core_clk_en == {CU{1'b1}}, "R2 wait", ack_valid, 1);
    end
    @(negedge clk); ack_ready = 1'b1;
    @(posedge clk); #5;
    chk(core_clk_en == '0 && snoop_irq_en, "R3 gated", core_clk_en, 0);
    @(negedge clk); ack_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(core_clk_en == '0 && bus_clk_en && intc_clk_en, "R4 halted", core_clk_en, 0);
    stop_req_n = 1'b1;
    wait_for_resume(n);
    chk(n == S + 1, "R5 release latency", n, S + 1);
    chk(core_clk_en == {CU{1'b1}} && !snoop_irq_en, "R5 ungated", core_clk_en, (1 << CU) - 1);
    count_resume(len);
    chk(len == RC, "R6 resume length", len, RC);
    chk(state_o == 0, "R6 back to run", state_o, 0);

    // Scenario B: release while acknowledge pending
    repeat (3) @(negedge clk);
    saw_gate = 0;
    stop_req_n = 1'b0;
    wait_for_ack(n);
    @(negedge clk); stop_req_n = 1'b1;
    repeat (S + 2) @(negedge clk);
    ack_ready = 1'b1;
    @(posedge clk); #5;
    chk(state_o == 3 && resume_ind, "R7 direct resume", state_o, 3);
    @(negedge clk); ack_ready = 1'b0;
    count_resume(len);
    chk(!saw_gate, "R7 core never gated", saw_gate, 0);

    // Scenario C: request arrives during resume
    repeat (3) @(negedge clk);
    stop_req_n = 1'b0;
    wait_for_ack(n);
    @(negedge clk); ack_ready = 1'b1;
    @(negedge clk); ack_ready = 1'b0; stop_req_n = 1'b1;
    wait_for_resume(n);
    @(negedge clk); stop_req_n = 1'b0;
    len = 1;
    do begin @(posedge clk); #5; if (resume_ind) len++; end while (resume_ind && len < 50);
    chk(len == RC, "R9 resume length kept", len, RC);
    chk(state_o == 0, "R9 run gap", state_o, 0);
    @(posedge clk); #5;
    chk(state_o == 1 && ack_valid, "R9 request taken", state_o, 1);
    @(negedge clk); ack_ready = 1'b1;
    @(negedge clk); ack_ready = 1'b0; stop_req_n = 1'b1;
    repeat (S + RC + 4) @(negedge clk);
    chk(state_o == 0, "R10 final run", state_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule